// File: doc/BRIEF.md
# Interrupt Vector Message Table

This block is the storage page behind a message-signalled interrupt capability. One 4 KiB address window holds, for each implemented vector, a four-dword entry: the message address (low and high halves), the message payload and a control word whose bit 0 masks that vector. The second half of the window holds a pending-bit array with one bit per vector. Software reaches the page through a simple request/response bus of 32-bit accesses. An interrupt dispatch controller sits beside the block. It reads the per-vector mask and pending bits straight from output buses and sets or clears pending bits with dedicated command strobes.

Every accepted dword write into an implemented entry raises a one-cycle mask-update event that carries the vector number. The dispatch controller uses this event to re-evaluate a vector whose mask may have just dropped while its pending bit was set. Two bulk commands act on the whole page in one cycle. The first returns the page to its reset image, with every dword zero and the mask bit of every implemented vector set. The second sets the mask bit of every implemented vector. While either bulk command is asserted, the bus is stalled.

Top module: `msix_vector_table`

## Requirements
- R1: After reset, every table dword of every implemented vector reads zero except the control word, which reads 0x00000001. `vecMasked` is all ones and `vecPending` is all zeros.
- R2: Vector n's entry starts at byte offset 16*n. Its fields are, in order: low address at +0, high address at +4, message data at +8, control at +12. An accepted dword write stores the full 32 bits. An accepted read returns its data on `rspRdata` with `rspValid` high in the next cycle. `rspValid` is low in cycles that follow no accepted read.
- R3: `vecMasked[n]` equals bit 0 of vector n's control word, and follows a control write from the next cycle on.
- R4: The dword offset is `reqAddr[11:2]`, so `reqAddr[1:0]` has no effect. Only `reqSize` = 2 (dword) takes effect. With `reqSize` 0 (byte), 1 (halfword) or 3, a write is ignored and a read returns zero.
- R5: The pending array reads as the dword at byte offset 0x800, where bit n is vector n and unused upper bits read zero. Every other offset from 0x800 upward, and every offset below 0x800 outside the implemented entries, reads zero. Bus writes to any of these offsets change nothing.
- R6: `pendSetValid` sets the pending bit of vector `pendSetVec`, and `pendClrValid` clears the bit of `pendClrVec`. When both name the same vector, the set wins. A vector number at or above `NUM_VEC` is ignored.
- R7: In the cycle after an accepted dword write to any field of implemented vector n, `updValid` is high for one cycle and `updVec` equals n. No other write raises `updValid`.
- R8: A `softReset` cycle puts the page in the R1 state at the next edge. A `maskAllCmd` cycle sets bit 0 of every implemented control word and leaves the other bits and the pending array unchanged.
- R9: `reqReady` is low in every cycle where `softReset` or `maskAllCmd` is high, and a request in such a cycle is not accepted. In all other cycles `reqReady` is high.
- R10: When `softReset` and a pending set occur in the same cycle, the pending array ends up all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request valid |
| reqReady | output | 1 | Bus request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset in the page |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 dword, 3 reserved |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Registered read data |
| pendSetValid | input | 1 | Set a pending bit |
| pendSetVec | input | 5 | Vector to set |
| pendClrValid | input | 1 | Clear a pending bit |
| pendClrVec | input | 5 | Vector to clear |
| softReset | input | 1 | Restore the whole page to its reset image |
| maskAllCmd | input | 1 | Mask every implemented vector |
| vecMasked | output | NUM_VEC | Per-vector mask bits |
| vecPending | output | NUM_VEC | Per-vector pending bits |
| updValid | output | 1 | Mask-update event after an entry write |
| updVec | output | 5 | Vector of the mask-update event |

## Verification
The properties assume that every input holds a known level from the first clock after reset. Pending commands may name any 5-bit vector, including ones above `NUM_VEC`, and the properties qualify on that range rather than assume it away. The bench drives all inputs low during reset and changes them only half a clock before an edge. Its random phase picks addresses from implemented entries, the two unimplemented vectors just above them, the pending dword, the rest of the pending half, and arbitrary offsets. It also mixes in non-dword sizes, same-vector set/clear collisions and bulk commands that overlap bus requests.

// File: rtl/msix_tbl_pkg.sv
package msix_tbl_pkg;

  localparam int MAX_VEC   = 32;
  localparam int VIDX_W    = 5;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int PEND_BASE = 'h800;

  // field inside a 16-byte vector entry, selected by offset bits [3:2]
  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } field_e;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrTable;   // accepted dword write into an implemented entry
    logic              rdStrobe;  // accepted read of any kind
    logic              rdTable;   // dword read of an implemented entry
    logic              rdPend;    // dword read of the pending dword
    logic [VIDX_W-1:0] vec;
    field_e            fld;
    logic              clearAll;
    logic              maskAll;
  } strobe_t;

endpackage

// File: rtl/msix_tbl_ctrl.sv
module msix_tbl_ctrl
  import msix_tbl_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              softReset,
  input  logic              maskAllCmd,
  output logic              reqReady,
  output strobe_t           strb,
  output logic              rspValid,
  output logic              updValid,
  output logic [VIDX_W-1:0] updVec
);

  localparam logic [6:0] VEC_LIM = 7'(NUM_VEC);
  localparam logic [9:0] PEND_DW = 10'(PEND_BASE >> 2);

  logic [9:0] dwIdx;
  logic       tableHit;
  logic       pendHit;
  logic       isWord;
  logic       bulkBusy;
  logic       accept;

  assign dwIdx    = reqAddr[AW-1:2];
  assign tableHit = !dwIdx[9] && (dwIdx[8:2] < VEC_LIM);
  assign pendHit  = (dwIdx == PEND_DW);
  assign isWord   = (reqSize == SIZE_WORD);
  assign bulkBusy = softReset || maskAllCmd;
  assign reqReady = !bulkBusy;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strb          = '0;
    strb.vec      = dwIdx[6:2];
    strb.fld      = field_e'(dwIdx[1:0]);
    strb.wrTable  = accept && reqWrite && isWord && tableHit;
    strb.rdStrobe = accept && !reqWrite;
    strb.rdTable  = isWord && tableHit;
    strb.rdPend   = isWord && pendHit;
    strb.clearAll = softReset;
    strb.maskAll  = maskAllCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      updValid <= 1'b0;
      updVec   <= '0;
    end else begin
      rspValid <= strb.rdStrobe;
      updValid <= strb.wrTable;
      if (strb.wrTable) updVec <= strb.vec;
    end
  end

  // a response only follows a request that the bus actually took
  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid) && !$past(reqWrite) && !$past(softReset) && !$past(maskAllCmd)));

  assert_event_word_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ($past(reqValid) && $past(reqWrite) && ($past(reqSize) == SIZE_WORD)));

  assert_event_table_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> !$past(reqAddr[AW-1]));

endmodule

// File: rtl/msix_tbl_data.sv
module msix_tbl_data
  import msix_tbl_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DW-1:0]      wrData,
  input  logic               pendSetValid,
  input  logic [VIDX_W-1:0]  pendSetVec,
  input  logic               pendClrValid,
  input  logic [VIDX_W-1:0]  pendClrVec,
  output logic [DW-1:0]      rdData,
  output logic [NUM_VEC-1:0] maskBits,
  output logic [NUM_VEC-1:0] pendBits
);

  localparam logic [VIDX_W:0] VEC_LIM = (VIDX_W + 1)'(NUM_VEC);
  localparam logic [DW-1:0]   CTRL_RST = DW'(1);

  logic [NUM_VEC-1:0][DW-1:0] loBus;
  logic [NUM_VEC-1:0][DW-1:0] hiBus;
  logic [NUM_VEC-1:0][DW-1:0] datBus;
  logic [NUM_VEC-1:0][DW-1:0] ctlBus;

  for (genvar g = 0; g < NUM_VEC; g++) begin : gVec
    logic [DW-1:0] loQ, hiQ, datQ, ctlQ;
    logic          pendQ;
    logic          wrHere, setHere, clrHere;

    assign wrHere  = strb.wrTable && (strb.vec == VIDX_W'(g));
    assign setHere = pendSetValid && (pendSetVec == VIDX_W'(g));
    assign clrHere = pendClrValid && (pendClrVec == VIDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ  <= '0;
        hiQ  <= '0;
        datQ <= '0;
        ctlQ <= CTRL_RST;
      end else if (strb.clearAll) begin
        loQ  <= '0;
        hiQ  <= '0;
        datQ <= '0;
        ctlQ <= CTRL_RST;
      end else begin
        if (wrHere) begin
          case (strb.fld)
            FLD_ADDR_LO: loQ  <= wrData;
            FLD_ADDR_HI: hiQ  <= wrData;
            FLD_DATA:    datQ <= wrData;
            FLD_CTRL:    ctlQ <= wrData;
            default:     ;
          endcase
        end
        if (strb.maskAll) ctlQ[0] <= 1'b1;
      end
    end

    // set outranks clear; bulk clear outranks both
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              pendQ <= 1'b0;
      else if (strb.clearAll) pendQ <= 1'b0;
      else if (setHere)       pendQ <= 1'b1;
      else if (clrHere)       pendQ <= 1'b0;
    end

    assign loBus[g]    = loQ;
    assign hiBus[g]    = hiQ;
    assign datBus[g]   = datQ;
    assign ctlBus[g]   = ctlQ;
    assign maskBits[g] = ctlQ[0];
    assign pendBits[g] = pendQ;
  end

  logic [DW-1:0] entryWord;
  logic [DW-1:0] rdNext;

  always_comb begin
    entryWord = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (strb.vec == VIDX_W'(i)) begin
        case (strb.fld)
          FLD_ADDR_LO: entryWord = loBus[i];
          FLD_ADDR_HI: entryWord = hiBus[i];
          FLD_DATA:    entryWord = datBus[i];
          default:     entryWord = ctlBus[i];
        endcase
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdPend)       rdNext = DW'(pendBits);
    else if (strb.rdTable) rdNext = entryWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strb.rdStrobe) rdData <= rdNext;
  end

  assert_bulk_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> ((&maskBits) && (pendBits == '0)));

  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskAll |=> (&maskBits));

  assert_clear_beats_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && pendSetValid) |=> (pendBits == '0));

  assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendSetValid && !strb.clearAll && ({1'b0, pendSetVec} < VEC_LIM))
      |=> (|(pendBits & (NUM_VEC'(1) << $past(pendSetVec)))));

  assert_pend_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendClrValid && !strb.clearAll && ({1'b0, pendClrVec} < VEC_LIM)
      && !(pendSetValid && (pendSetVec == pendClrVec)))
      |=> !(|(pendBits & (NUM_VEC'(1) << $past(pendClrVec)))));

  // the bus never alters pending state
  assert_pend_bus_ro_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!pendSetValid && !pendClrValid && !strb.clearAll) |=> $stable(pendBits));

endmodule

// File: rtl/msix_vector_table.sv
module msix_vector_table
  import msix_tbl_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [11:0]        reqAddr,
  input  logic [1:0]         reqSize,
  input  logic [31:0]        reqWdata,
  output logic               rspValid,
  output logic [31:0]        rspRdata,
  input  logic               pendSetValid,
  input  logic [4:0]         pendSetVec,
  input  logic               pendClrValid,
  input  logic [4:0]         pendClrVec,
  input  logic               softReset,
  input  logic               maskAllCmd,
  output logic [NUM_VEC-1:0] vecMasked,
  output logic [NUM_VEC-1:0] vecPending,
  output logic               updValid,
  output logic [4:0]         updVec
);

  strobe_t strb;

  msix_tbl_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .softReset  (softReset),
    .maskAllCmd (maskAllCmd),
    .reqReady   (reqReady),
    .strb       (strb),
    .rspValid   (rspValid),
    .updValid   (updValid),
    .updVec     (updVec)
  );

  msix_tbl_data #(.NUM_VEC(NUM_VEC)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (reqWdata),
    .pendSetValid (pendSetValid),
    .pendSetVec   (pendSetVec),
    .pendClrValid (pendClrValid),
    .pendClrVec   (pendClrVec),
    .rdData       (rspRdata),
    .maskBits     (vecMasked),
    .pendBits     (vecPending)
  );

endmodule

// File: tb/msix_vector_table_tb.sv
`timescale 1ns/1ps
module msix_vector_table_tb;

  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqWrite;
  logic [11:0]   reqAddr;
  logic [1:0]    reqSize;
  logic [31:0]   reqWdata;
  logic          reqReady, rspValid;
  logic [31:0]   rspRdata;
  logic          pendSetValid, pendClrValid;
  logic [4:0]    pendSetVec, pendClrVec;
  logic          softReset, maskAllCmd;
  logic [NV-1:0] vecMasked, vecPending;
  logic          updValid;
  logic [4:0]    updVec;

  always #2.5 clk = ~clk;

  msix_vector_table #(.NUM_VEC(NV)) u_dut (.*);

  // behavioural model
  logic [31:0] mTbl [NV*4];
  logic [31:0] mPend;
  bit          eRsp, eUpd;
  logic [31:0] eRdata;
  int          eUpdVec;
  int          nCmp = 0, nBad = 0;
  bit          done = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[30:16], seed[15:0] ^ seed[31:16], 1'b0} ^ {1'b0, seed[31:1]};
  endfunction

  task automatic mReset();
    for (int i = 0; i < NV*4; i++) mTbl[i] = ((i % 4) == 3) ? 32'd1 : 32'd0;
    mPend = '0;
  endtask

  function automatic logic [31:0] mRead(logic [11:0] a, logic [1:0] sz);
    int dw = int'(a[11:2]);
    if (sz != 2'd2) return '0;
    if (dw < NV*4) return mTbl[dw];
    if (dw == 'h200) return mPend;
    return '0;
  endfunction

  task automatic chk(string req, string ctx, logic [31:0] got, logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s (%s) at %0t: got %h expected %h", req, ctx, $time, got, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = 0; reqWrite = 0; reqAddr = '0; reqSize = 2'd2; reqWdata = '0;
    pendSetValid = 0; pendSetVec = '0; pendClrValid = 0; pendClrVec = '0;
    softReset = 0; maskAllCmd = 0;
  endtask

  // inputs already driven: check ready, step model, compare after the edge
  task automatic step(string ctx);
    bit bulk, acc, word;
    int dw;
    logic [NV-1:0] mMask;
    #1;
    bulk = softReset || maskAllCmd;
    chk("R9", ctx, 32'(reqReady), 32'(!bulk));
    acc  = reqValid && !bulk;
    dw   = int'(reqAddr[11:2]);
    word = (reqSize == 2'd2);
    eRsp = acc && !reqWrite;
    if (eRsp) eRdata = mRead(reqAddr, reqSize);
    eUpd = acc && reqWrite && word && (dw < NV*4);
    if (eUpd) eUpdVec = dw / 4;
    if (softReset) mReset();
    else begin
      if (maskAllCmd) for (int i = 0; i < NV; i++) mTbl[i*4+3][0] = 1'b1;
      if (eUpd) mTbl[dw] = reqWdata;
      if (pendClrValid && pendClrVec < NV) mPend[pendClrVec] = 1'b0;
      if (pendSetValid && pendSetVec < NV) mPend[pendSetVec] = 1'b1;
    end
    @(negedge clk);
    for (int i = 0; i < NV; i++) mMask[i] = mTbl[i*4+3][0];
    chk("R3", ctx, 32'(vecMasked), 32'(mMask));
    chk("R6", ctx, 32'(vecPending), 32'(mPend[NV-1:0]));
    chk("R2", ctx, 32'(rspValid), 32'(eRsp));
    if (eRsp) chk("R2", ctx, rspRdata, eRdata);
    chk("R7", ctx, 32'(updValid), 32'(eUpd));
    if (eUpd) chk("R7", ctx, 32'(updVec), 32'(eUpdVec));
    clearIn();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz, string ctx);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d; reqSize = sz;
    step(ctx);
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] sz, string ctx);
    reqValid = 1; reqWrite = 0; reqAddr = a; reqSize = sz;
    step(ctx);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    clearIn();
    rstN = 0;
    mReset();
    eRsp = 0; eUpd = 0; eRdata = '0; eUpdVec = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset image
    step("R1");
    rd(12'h00C, 2'd2, "R1");
    rd(12'h070, 2'd2, "R1");
    rd(12'h07C, 2'd2, "R1");

    // R2: all four fields of one entry
    wr(12'h030, 32'hA0A0_0001, 2'd2, "R2");
    wr(12'h034, 32'hB0B0_0002, 2'd2, "R2");
    wr(12'h038, 32'hC0C0_0003, 2'd2, "R2");
    wr(12'h03C, 32'hFFFF_FFFF, 2'd2, "R2");
    for (int k = 0; k < 4; k++) rd(12'(12'h030 + 4*k), 2'd2, "R2");

    // R3: unmask a vector
    wr(12'h03C, 32'h0000_0000, 2'd2, "R3");
    wr(12'h07C, 32'hFFFF_FFFE, 2'd2, "R3");

    // R4: low address bits ignored, non-dword sizes
    wr(12'h013, 32'h1357_9BDF, 2'd2, "R4");
    rd(12'h011, 2'd2, "R4");
    wr(12'h014, 32'hDEAD_BEEF, 2'd0, "R4");
    wr(12'h014, 32'hDEAD_BEEF, 2'd1, "R4");
    rd(12'h014, 2'd2, "R4");
    rd(12'h010, 2'd1, "R4");
    rd(12'h010, 2'd3, "R4");

    // R5: pending layout, read-only pending region, unimplemented space
    pendSetValid = 1; pendSetVec = 5'd2; step("R5");
    pendSetValid = 1; pendSetVec = 5'd5; step("R5");
    rd(12'h800, 2'd2, "R5");
    wr(12'h800, 32'h0000_0000, 2'd2, "R5");
    rd(12'h800, 2'd2, "R5");
    rd(12'h804, 2'd2, "R5");
    wr(12'h080, 32'h5555_AAAA, 2'd2, "R5");
    rd(12'h080, 2'd2, "R5");
    rd(12'hFFC, 2'd2, "R5");

    // R6: set wins over clear, out of range ignored
    pendSetValid = 1; pendSetVec = 5'd5; pendClrValid = 1; pendClrVec = 5'd5; step("R6");
    pendClrValid = 1; pendClrVec = 5'd2; step("R6");
    pendSetValid = 1; pendSetVec = 5'd20; step("R6");
    pendClrValid = 1; pendClrVec = 5'd9; step("R6");

    // R7: back-to-back writes to different vectors
    wr(12'h000, 32'h1, 2'd2, "R7");
    wr(12'h07C, 32'h0, 2'd2, "R7");

    // R8 / R9: mask-all with a request held up
    reqValid = 1; reqWrite = 1; reqAddr = 12'h00C; reqWdata = 32'h0; maskAllCmd = 1;
    step("R9");
    rd(12'h07C, 2'd2, "R8");
    maskAllCmd = 1; step("R8");

    // R10 / R8: soft reset against a pending set and a read
    pendSetValid = 1; pendSetVec = 5'd1;
    reqValid = 1; reqWrite = 0; reqAddr = 12'h030;
    softReset = 1; step("R10");
    rd(12'h030, 2'd2, "R8");
    rd(12'h03C, 2'd2, "R8");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = rnd();
      int pick = int'(r[2:0]);
      logic [31:0] r2 = rnd();
      reqValid = r[3] | r[4];
      reqWrite = r[5];
      case (pick)
        0, 1, 2, 3, 4: reqAddr = 12'({r2[7:0] % 8'd10, r2[9:8], r2[11:10]});
        5:             reqAddr = 12'h800 | 12'(r2[1:0]);
        6:             reqAddr = 12'h804 | 12'(r2[9:0]);
        default:       reqAddr = r2[11:0];
      endcase
      reqSize  = (r[8:6] == 3'd0) ? r[10:9] : 2'd2;
      reqWdata = rnd();
      pendSetValid = (r[12:11] == 2'd0);
      pendSetVec   = 5'(r2[20:16] % 5'd10);
      pendClrValid = (r[14:13] == 2'd0);
      pendClrVec   = r[15] ? pendSetVec : 5'(r2[26:22] % 5'd10);
      softReset    = (r[21:16] == 6'd0);
      maskAllCmd   = (r[26:22] == 5'd1);
      step("RND");
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

endmodule